// File: doc/BRIEF.md
# UART Receiver with Wakeup Standby

This block is the receive half of an asynchronous serial port. It watches the line with a sampling strobe at sixteen times the bit rate, which is supplied from outside. It takes in characters of 8 or 9 data bits, least significant bit first, with an optional parity bit. It keeps a small status byte holding data-ready, idle-line, overrun, noise, framing-error and parity-error flags. Software takes a character by reading the status strobe and then the data strobe, and this pair of reads also clears the flags.

Software can put the receiver into standby. In standby the receiver keeps watching the line but raises no flag and stores no character. Hardware leaves standby by itself when the selected wakeup event happens. With the wake select at 0, the event is an idle line. With the wake select at 1, the event is a character whose top data bit is 1, and that character is kept as a normal received character. This lets a node on a shared line skip messages that are meant for other nodes.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `status` reads 0x00, `rx_data` reads 0 and `standby` is 0.
- R2: A frame is a 0 start bit, 8 data bits (LSB first), an optional parity bit and a stop bit. When the frame completes, the data appears on `rx_data` and data-ready (status bit 5) is set.
- R3: With `nine_bit`=1 the frame carries 9 data bits. With `par_en`=1 a parity bit follows the data, even parity when `par_odd`=0 and odd parity when `par_odd`=1. A parity mismatch sets status bit 0.
- R4: A stop bit sampled as 0 sets the framing-error flag (status bit 1). The character is still stored.
- R5: Each bit is sampled on ticks 7, 8 and 9 of its sixteen. The value is the majority of the three samples. If any bit of the frame has samples that disagree, the noise flag (status bit 2) is set.
- R6: If a frame completes while data-ready is already 1, the overrun flag (status bit 3) is set. `rx_data` and the other flags are left unchanged.
- R7: After the line has been at 1 for one frame length (10, 11 or 12 bit times, including start, parity and stop), the idle flag (status bit 4) is set once per idle stretch.
- R8: A `stat_rd` pulse while any flag is 1, followed later by a `data_rd` pulse, clears status bits 5..0. A `data_rd` pulse with no armed `stat_rd` before it has no effect.
- R9: While `rx_en` is 0 the receiver ignores the line. No flag is set and `rx_data` does not change.
- R10: A `standby_set` pulse sets `standby` to 1. While `standby` is 1, no flag is set and `rx_data` does not change, except for the waking character of R12.
- R11: With `wake_sel`=0, an idle stretch (R7) during standby clears `standby` without setting the idle flag. The next frame is then received normally.
- R12: With `wake_sel`=1, a frame in standby whose top data bit (bit 7, or bit 8 when `nine_bit`=1) is 0 is discarded. A frame whose top data bit is 1 clears `standby`, is stored and sets data-ready.
- R13: Status bits 7 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling strobe, 16 per bit time |
| rxd | input | 1 | Serial input line (idle high) |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wake_sel | input | 1 | 0: idle-line wakeup, 1: top-bit wakeup |
| standby_set | input | 1 | Pulse: enter standby |
| stat_rd | input | 1 | Pulse: status read |
| data_rd | input | 1 | Pulse: data read |
| status | output | 8 | Flags: bit5 ready, 4 idle, 3 overrun, 2 noise, 1 framing, 0 parity |
| rx_data | output | 9 | Last stored character |
| standby | output | 1 | Standby state |

## Verification
The bench covers these corner cases:
- A single sample glitch in the middle of a data bit must leave the character intact and set only the noise flag. A design that used one sample, or got the majority wrong, would corrupt the character.
- A low stop bit must flag a framing error. The line staying low afterwards must only cause a false start that is dropped. A design that did not validate the start bit would invent a second character.
- A second character arriving on a full buffer must raise overrun and leave the first character in place. A design that wrote the new character anyway would lose the first one.
- In standby, a discarded character must leave the data and flags untouched. A waking top-bit character must be kept. An idle wake must leave no idle flag behind. A design that let flags through in standby would break each of these.
- A data read without a prior armed status read must clear nothing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int FL_DRDY = 5;
  localparam int FL_IDLE = 4;
  localparam int FL_OVR  = 3;
  localparam int FL_NF   = 2;
  localparam int FL_FE   = 1;
  localparam int FL_PE   = 0;
  localparam int FL_W    = 6;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  // first stage takes the raw line, the others copy their neighbour
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                line,
  input  logic                nine_bit,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                busy,
  output logic                done,
  output logic [DATA_MAX-1:0] data,
  output logic                noise,
  output logic                ferr,
  output logic                perr
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_MAX);
  localparam logic [CW-1:0] SMP0 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SMP1 = CW'(OSR/2);
  localparam logic [CW-1:0] SMP2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d, last_idx;
  logic [1:0] smp_q, smp_d;
  logic [DATA_MAX-1:0] sh_q, sh_d;
  logic nacc_q, nacc_d, pacc_q, pacc_d, pbad_q, pbad_d;
  logic fin, maj, split;

  always_comb begin
    maj      = maj3(smp_q[0], smp_q[1], line);
    split    = !((smp_q[0] == smp_q[1]) && (smp_q[1] == line));
    last_idx = nine_bit ? IW'(DATA_MAX - 1) : IW'(DATA_MAX - 2);
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    smp_d  = smp_q;
    sh_d   = sh_q;
    nacc_d = nacc_q;
    pacc_d = pacc_q;
    pbad_d = pbad_q;
    fin    = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      if (st_q == RX_IDLE) begin
        if (!line) begin
          st_d   = RX_START;
          cnt_d  = CW'(1);
          sh_d   = '0;
          nacc_d = 1'b0;
          pacc_d = 1'b0;
          pbad_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == SMP0) smp_d[0] = line;
        if (cnt_q == SMP1) smp_d[1] = line;
        if (cnt_q == SMP2) begin
          nacc_d = nacc_q | split;
          case (st_q)
            RX_START: if (maj) st_d = RX_IDLE;
            RX_DATA: begin
              sh_d[idx_q] = maj;
              pacc_d      = pacc_q ^ maj;
            end
            RX_PAR:  pbad_d = pacc_q ^ maj ^ par_odd;
            RX_STOP: begin
              st_d = RX_IDLE;
              fin  = 1'b1;
            end
            default: ;
          endcase
        end
        if (cnt_q == LAST) begin
          case (st_q)
            RX_START: begin
              st_d  = RX_DATA;
              idx_d = '0;
            end
            RX_DATA: begin
              if (idx_q == last_idx) st_d = par_en ? RX_PAR : RX_STOP;
              else                   idx_d = idx_q + IW'(1);
            end
            RX_PAR:  st_d = RX_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      smp_q  <= '0;
      sh_q   <= '0;
      nacc_q <= 1'b0;
      pacc_q <= 1'b0;
      pbad_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      smp_q  <= smp_d;
      sh_q   <= sh_d;
      nacc_q <= nacc_d;
      pacc_q <= pacc_d;
      pbad_q <= pbad_d;
      done   <= fin;
    end
  end

  // result registers, loaded only when a frame finishes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      noise <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
    end else if (fin) begin
      data  <= sh_q;
      noise <= nacc_q | split;
      ferr  <= !maj;
      perr  <= pbad_q & par_en;
    end
  end

  assign busy = (st_q != RX_IDLE);
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int OSR       = 16,
  parameter int FRAME_MAX = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic busy,
  input  logic line,
  input  logic nine_bit,
  input  logic par_en,
  output logic idle_evt
);
  localparam int TW = $clog2(OSR * FRAME_MAX + 1);

  logic [TW-1:0] cnt_q, cnt_d, thr;
  logic evt_d, quiet;

  always_comb begin
    thr   = TW'(OSR * (FRAME_MAX - 2 + int'(nine_bit) + int'(par_en)));
    quiet = en && !busy && line;
    cnt_d = cnt_q;
    evt_d = 1'b0;
    if (!quiet) begin
      cnt_d = '0;
    end else if (tick && (cnt_q != thr)) begin
      cnt_d = cnt_q + TW'(1);
      evt_d = (cnt_q == thr - TW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      idle_evt <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      idle_evt <= evt_d;
    end
  end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wake_sel,
  input  logic       standby_set,
  input  logic       stat_rd,
  input  logic       data_rd,
  output logic [7:0] status,
  output logic [8:0] rx_data,
  output logic       standby
);
  localparam int DW = 9;

  logic line_s, busy, fr_done, fr_noise, fr_ferr, fr_perr, idle_evt;
  logic [DW-1:0] fr_data;
  logic [FL_W-1:0] flags_q, flags_d, base;
  logic [DW-1:0] data_q, data_d;
  logic sb_q, sb_d, arm_q, arm_d, clr, msb, accept, wake, data_ld;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  rx_framer #(.OSR(OSR), .DATA_MAX(DW)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .line(line_s),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .busy(busy), .done(fr_done), .data(fr_data),
    .noise(fr_noise), .ferr(fr_ferr), .perr(fr_perr)
  );

  rx_idle_det #(.OSR(OSR), .FRAME_MAX(12)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .busy(busy),
    .line(line_s), .nine_bit(nine_bit), .par_en(par_en), .idle_evt(idle_evt)
  );

  always_comb begin
    clr     = data_rd & arm_q;
    base    = clr ? '0 : flags_q;
    msb     = nine_bit ? fr_data[DW-1] : fr_data[DW-2];
    accept  = fr_done & (!sb_q | (wake_sel & msb));
    wake    = sb_q & ((fr_done & wake_sel & msb) | (idle_evt & !wake_sel));
    flags_d = base;
    data_d  = data_q;
    data_ld = 1'b0;
    if (accept) begin
      if (base[FL_DRDY]) begin
        flags_d[FL_OVR] = 1'b1;
      end else begin
        flags_d[FL_DRDY] = 1'b1;
        flags_d[FL_NF]   = base[FL_NF] | fr_noise;
        flags_d[FL_FE]   = base[FL_FE] | fr_ferr;
        flags_d[FL_PE]   = base[FL_PE] | fr_perr;
        data_d           = fr_data;
        data_ld          = 1'b1;
      end
    end
    if (idle_evt && !sb_q) flags_d[FL_IDLE] = 1'b1;
    sb_d  = standby_set | (sb_q & !wake);
    arm_d = clr ? 1'b0 : (arm_q | (stat_rd & (|flags_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sb_q    <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      sb_q    <= sb_d;
      arm_q   <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_ld) data_q <= data_d;
  end

  assign status  = {2'b00, flags_q};
  assign rx_data = data_q;
  assign standby = sb_q;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       wake_sel,
  input logic       standby,
  input logic [7:0] status,
  input logic [8:0] rx_data
);
  // R13
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  // R9
  off_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rx_en) |-> !$rose(status[5]));

  // R9
  off_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rx_en) |-> $stable(rx_data));

  // R10
  standby_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !$past(standby));

  // R12
  standby_ready_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[5]) && $past(standby)) |-> ($past(wake_sel) && !standby));

  // R6
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> status[5]);
endmodule

bind uart_wake_rx uart_wake_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wake_sel(wake_sel),
  .standby(standby), .status(status), .rx_data(rx_data)
);

// File: tb/uart_wake_rx_tb_top.sv
module uart_wake_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic rx_en = 1'b0, nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic wake_sel = 1'b0, standby_set = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] status;
  logic [8:0] rx_data;
  logic standby;
  logic [1:0] div = 2'd0;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [5:0] exp_flags = '0;
  logic [8:0] exp_data = '0;
  bit exp_sb = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd2);
  end

  uart_wake_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .wake_sel(wake_sel), .standby_set(standby_set), .stat_rd(stat_rd),
    .data_rd(data_rd), .status(status), .rx_data(rx_data), .standby(standby)
  );

  task automatic check(input string req);
    tests++;
    if (status !== {2'b00, exp_flags} || rx_data !== exp_data || standby !== exp_sb) begin
      fails++;
      $display("FAIL %s: status=%02h data=%03h standby=%0b expected status=%02h data=%03h standby=%0b",
               req, status, rx_data, standby, {2'b00, exp_flags}, exp_data, exp_sb);
    end
  endtask

  // reference behaviour for one completed frame
  task automatic model_frame(input logic [8:0] d, input bit nz, input bit fe, input bit pe);
    bit top;
    if (!rx_en) return;
    top = nine_bit ? d[8] : d[7];
    if (exp_sb) begin
      if (!(wake_sel && top)) return;
      exp_sb = 1'b0;
    end
    if (exp_flags[5]) exp_flags[3] = 1'b1;
    else begin
      exp_flags[5] = 1'b1;
      exp_flags[2] = exp_flags[2] | nz;
      exp_flags[1] = exp_flags[1] | fe;
      exp_flags[0] = exp_flags[0] | pe;
      exp_data = d;
    end
  endtask

  task automatic model_idle();
    if (exp_sb) begin
      if (!wake_sel) exp_sb = 1'b0;
    end else exp_flags[4] = 1'b1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic clear_seq();
    pulse(stat_rd);
    pulse(data_rd);
    @(negedge clk);
    exp_flags = '0;
  endtask

  task automatic put_bit(input logic v, input bit glitch);
    rxd = v;
    repeat (32) @(negedge clk);
    if (glitch) rxd = !v;
    repeat (4) @(negedge clk);
    rxd = v;
    repeat (28) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit par_wrong, input bit stop_v, input int gbit);
    int nb;
    bit p;
    nb = nine_bit ? 9 : 8;
    p = par_odd;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    @(negedge clk);
    while (!tick16) @(negedge clk);
    put_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) put_bit(d[i], gbit == i);
    if (par_en) put_bit(p ^ par_wrong, 1'b0);
    put_bit(stop_v, 1'b0);
    rxd = 1'b1;
    model_frame(nine_bit ? d : {1'b0, d[7:0]}, gbit >= 0, !stop_v, par_en && par_wrong);
  endtask

  task automatic wait_idle();
    repeat (13 * 64) @(negedge clk);
    if (rx_en) model_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    send(9'h055, 0, 1, -1);
    check("R9 receiver off ignores frame");

    rx_en = 1'b1;
    wait_idle();
    check("R7 idle flag after frame-length high");

    clear_seq();
    check("R8 clear sequence");

    send(9'h0A5, 0, 1, -1);
    check("R2 8-bit frame stored, ready set");

    pulse(data_rd);
    @(negedge clk);
    check("R8 data read without status read has no effect");

    send(9'h03C, 0, 1, -1);
    check("R6 overrun keeps first character");
    clear_seq();
    check("R8 clear after overrun");

    send(9'h00F, 0, 0, -1);
    repeat (64) @(negedge clk);
    check("R4 framing error, trailing low is a false start");
    clear_seq();

    send(9'h081, 0, 1, 3);
    check("R5 glitch outvoted, noise flagged");
    clear_seq();

    nine_bit = 1'b1; par_en = 1'b1; par_odd = 1'b0;
    send(9'h1C3, 0, 1, -1);
    check("R3 9-bit even parity good");
    clear_seq();
    send(9'h1C3, 1, 1, -1);
    check("R3 9-bit parity error");
    clear_seq();
    nine_bit = 1'b0; par_odd = 1'b1;
    send(9'h00F, 0, 1, -1);
    check("R3 8-bit odd parity good");
    clear_seq();
    par_en = 1'b0; par_odd = 1'b0;

    wake_sel = 1'b1;
    pulse(standby_set);
    @(negedge clk);
    exp_sb = 1'b1;
    check("R10 standby set");
    send(9'h012, 0, 1, -1);
    check("R12 top bit 0 discarded in standby");
    send(9'h092, 0, 1, -1);
    check("R12 top bit 1 wakes and is stored");
    clear_seq();

    wake_sel = 1'b0;
    pulse(standby_set);
    @(negedge clk);
    exp_sb = 1'b1;
    send(9'h044, 0, 1, -1);
    check("R10 frame discarded in idle-wake standby");
    wait_idle();
    check("R11 idle wake clears standby, no idle flag");
    send(9'h066, 0, 1, -1);
    check("R11 frame after idle wake received");
    if (status[7:6] !== 2'b00) begin
      fails++;
      $display("FAIL R13: status[7:6]=%b expected 00", status[7:6]);
    end
    tests++;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule